// File: doc/BRIEF.md
# Exception Return Address Capture

This block records the return address when the processor takes an exception. The pipeline raises a one-cycle take strobe. With it come the PC of the faulting instruction, a flag that says whether that instruction sits in a branch delay slot, and a 4-bit cause code. On that strobe the block stores a saved PC and a status bit.

When the faulting instruction is in a delay slot, the saved PC moves back one instruction so that it points at the branch. A system call moves the saved PC forward one instruction, so that execution resumes after the call. The two adjustments add, which means a system call in a delay slot saves its own PC. The block also hands the pipeline the next value of its delay-slot flag, which is forced to zero while an exception is taken.

Between strobes the saved PC holds its value. Exception-return software may overwrite it through a plain write port.

Top module: `exc_pc_capture`

## Requirements
- R1: After reset, `epc_o` is 0 and `slot_exc_o` is 0.
- R2: When a take strobe comes with `in_slot_i`=0 and a cause other than the system-call code 4'hB, `epc_o` equals the strobed `pc_i` from the cycle after the strobe.
- R3: When a take strobe comes with `in_slot_i`=1 and a non-system-call cause, `epc_o` equals `pc_i` minus 4 and `slot_exc_o` is 1.
- R4: When a take strobe comes with cause 4'hB and `in_slot_i`=0, `epc_o` equals `pc_i` plus 4.
- R5: When a take strobe comes with cause 4'hB and `in_slot_i`=1, both adjustments apply and `epc_o` equals `pc_i`.
- R6: `slot_flag_o` is 0 while `take_i` is high. Otherwise it equals `in_slot_i`.
- R7: The plus 4 and minus 4 adjustments wrap modulo 2^32. PC 0 in a delay slot saves 32'hFFFFFFFC, and a system call at 32'hFFFFFFFC saves 0.
- R8: Without a take strobe, `epc_o` and `slot_exc_o` hold their values, whatever `pc_i` does.
- R9: A take strobe with `in_slot_i`=0 clears `slot_exc_o`.
- R10: `sw_wr_i` loads `sw_data_i` into `epc_o` one cycle later and leaves `slot_exc_o` unchanged. A take strobe in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | One-cycle exception-take strobe |
| pc_i | input | 32 | PC of the faulting instruction |
| in_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| cause_i | input | 4 | Encoded exception cause; 4'hB is a system call |
| sw_wr_i | input | 1 | Software write strobe for the saved PC |
| sw_data_i | input | 32 | Value for a software write |
| epc_o | output | 32 | Saved exception PC |
| slot_exc_o | output | 1 | Exception was taken in a delay slot |
| slot_flag_o | output | 1 | Next value of the pipeline delay-slot flag |

## Verification
The saved PC and the status bit are registered, so each is due one clock after the edge that samples the strobe or the write. `slot_flag_o` is combinational and is due in the same cycle as its inputs. The bench drives inputs at the falling edge and checks `slot_flag_o` a moment later, while the strobe is still high. It lowers the strobe at the next falling edge, after one rising edge has passed, and checks the registered results there. The hold checks let several idle edges go by while `pc_i` keeps changing, then sample at a falling edge.

// File: rtl/exc_pc_capture.sv
module exc_pc_capture #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter logic [CW-1:0] SYSCALL_CODE = 4'hB,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [AW-1:0] pc_i,
  input  logic          in_slot_i,
  input  logic [CW-1:0] cause_i,
  input  logic          sw_wr_i,
  input  logic [AW-1:0] sw_data_i,
  output logic [AW-1:0] epc_o,
  output logic          slot_exc_o,
  output logic          slot_flag_o
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic          is_sys;
  logic [AW-1:0] back_pc;
  logic [AW-1:0] next_epc;

  assign is_sys      = (cause_i == SYSCALL_CODE);
  assign back_pc     = in_slot_i ? pc_i - STEP_V : pc_i;
  assign next_epc    = is_sys ? back_pc + STEP_V : back_pc;
  assign slot_flag_o = take_i ? 1'b0 : in_slot_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_o      <= '0;
      slot_exc_o <= 1'b0;
    end else if (take_i) begin
      epc_o      <= next_epc;
      slot_exc_o <= in_slot_i;
    end else if (sw_wr_i) begin
      epc_o      <= sw_data_i;
    end
  end

  // R1: reset values
  a_r1_reset: assert property (@(posedge clk) !rst_n |=> (epc_o == '0 && !slot_exc_o));

  // R2: plain exception saves the faulting PC
  a_r2_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !in_slot_i && cause_i != SYSCALL_CODE) |=> epc_o == $past(pc_i));

  // R3: delay-slot exception points back at the branch
  a_r3_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && in_slot_i && cause_i != SYSCALL_CODE) |=> (epc_o == $past(pc_i) - STEP_V && slot_exc_o));

  // R4: system call resumes after the call
  a_r4_sys: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !in_slot_i && cause_i == SYSCALL_CODE) |=> epc_o == $past(pc_i) + STEP_V);

  // R5: system call in a delay slot saves its own PC
  a_r5_sys_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && in_slot_i && cause_i == SYSCALL_CODE) |=> epc_o == $past(pc_i));

  // R6: delay-slot flag is cleared while an exception is taken
  always_comb begin
    if (take_i) a_r6_flag_clr: assert (slot_flag_o == 1'b0);
  end

  // R8: state holds between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !sw_wr_i) |=> ($stable(epc_o) && $stable(slot_exc_o)));

  // R9: non-slot exception clears the status bit
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !in_slot_i) |=> !slot_exc_o);

  // R10: a software write loads the saved PC and leaves the status bit alone
  a_r10_swwr: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && sw_wr_i) |=> (epc_o == $past(sw_data_i) && $stable(slot_exc_o)));

endmodule

// File: tb/sim_exc_pc_capture.sv
module sim_exc_pc_capture;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        take_i = 0;
  logic [31:0] pc_i = '0;
  logic        in_slot_i = 0;
  logic [3:0]  cause_i = '0;
  logic        sw_wr_i = 0;
  logic [31:0] sw_data_i = '0;
  logic [31:0] epc_o;
  logic        slot_exc_o;
  logic        slot_flag_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_pc_capture u0 (.*);

  // Each vector holds {pc, in_slot, cause, expected epc, expected status}.
  // The expected values come from the requirements.
  localparam int NV = 8;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_1000, 1'b0, 4'h3, 32'h0000_1000, 1'b0},  // R2
    {32'h0000_2004, 1'b1, 4'h3, 32'h0000_2000, 1'b1},  // R3
    {32'h0000_3000, 1'b0, 4'hB, 32'h0000_3004, 1'b0},  // R4
    {32'h0000_4008, 1'b1, 4'hB, 32'h0000_4008, 1'b1},  // R5
    {32'h0000_0000, 1'b1, 4'h0, 32'hFFFF_FFFC, 1'b1},  // R7 wrap down
    {32'hFFFF_FFFC, 1'b0, 4'hB, 32'h0000_0000, 1'b0},  // R7 wrap up, R9 clear
    {32'h0000_6000, 1'b0, 4'hC, 32'h0000_6000, 1'b0},  // R2
    {32'h0000_7010, 1'b1, 4'hF, 32'h0000_700C, 1'b1}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Raise the strobe for one clock, check the flag while it is high,
  // then check the registered results one edge later.
  task automatic take(input logic [31:0] pc, input logic sl, input logic [3:0] c,
                      input logic [31:0] e_epc, input logic e_st, input string req);
    @(negedge clk);
    pc_i = pc; in_slot_i = sl; cause_i = c; take_i = 1;
    #1 chk("R6 flag cleared during take", {31'b0, slot_flag_o}, 32'd0);
    @(negedge clk);
    take_i = 0;
    chk(req, epc_o, e_epc);
    chk({req, " status"}, {31'b0, slot_exc_o}, {31'b0, e_st});
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk("R1 epc reset", epc_o, 32'd0);
    chk("R1 status reset", {31'b0, slot_exc_o}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      take(VEC[i][69:38], VEC[i][37], VEC[i][36:33], VEC[i][32:1], VEC[i][0], "R2-R5/R7 vector epc");
    end

    // R8: idle edges with pc_i moving must not disturb the saved state
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      pc_i = 32'hA000_0000 + k; in_slot_i = k[0];
    end
    @(negedge clk);
    chk("R8 epc hold", epc_o, 32'h0000_700C);
    chk("R8 status hold", {31'b0, slot_exc_o}, 32'd1);

    // R6: without a take, the flag follows in_slot_i
    in_slot_i = 1; #1 chk("R6 flag follows slot", {31'b0, slot_flag_o}, 32'd1);
    in_slot_i = 0; #1 chk("R6 flag follows slot", {31'b0, slot_flag_o}, 32'd0);

    // R10: a software write loads the saved PC and keeps the status bit
    @(negedge clk);
    sw_wr_i = 1; sw_data_i = 32'hDEAD_BEEF;
    @(negedge clk);
    sw_wr_i = 0;
    chk("R10 sw write", epc_o, 32'hDEAD_BEEF);
    chk("R10 status unchanged", {31'b0, slot_exc_o}, 32'd1);

    // R10: a take in the same cycle as a write wins
    @(negedge clk);
    sw_wr_i = 1; sw_data_i = 32'h1234_5678;
    pc_i = 32'h0000_8000; in_slot_i = 0; cause_i = 4'h2; take_i = 1;
    @(negedge clk);
    sw_wr_i = 0; take_i = 0;
    chk("R10 take wins over write", epc_o, 32'h0000_8000);
    chk("R9 status cleared", {31'b0, slot_exc_o}, 32'd0);

    // R1: reset again after activity
    rst_n = 0;
    @(negedge clk);
    chk("R1 epc re-reset", epc_o, 32'd0);
    rst_n = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule